// File: doc/BRIEF.md
# Center-Aligned Triangle PWM Generator

This block produces one pulse-width-modulated output from an up-down counter. The counter climbs from zero to a programmable frame size, turns, falls back to zero and repeats. The output is high while the count is below the active compare value, so every pulse is centred on the bottom of the ramp and sits at the same place in every frame. A one-cycle strobe marks each turning point, which lets a converter sample in the middle of the pulse.

The duty value is written into a holding register at any time. It moves into the active compare register at both turning points, so a new duty can take effect once per half frame. An output polarity input inverts the compare result.

A level run input controls the counter. While it is low the counter is held at zero and the frame size is sampled. When it is high the counter runs. Instances that are released on the same cycle stay in lock step. Instances that are released on different cycles keep that offset for as long as they run, which gives complementary or multi-phase drive.

Top module: `triPwmGen`

## Requirements
- R1: After release the count runs 0,1,…,F,F-1,…,1 and repeats with a period of 2F cycles. `peakStb` is high for exactly the cycles where the count equals F. `valleyStb` is high for exactly the cycles where the count equals 0. The first running cycle is a valley.
- R2: While running, `pwmOut` equals (count < active duty) XOR `invert`. The comparison is unsigned and uses CNT_W+1 bits.
- R3: An active duty of 0 gives a raw output that is constantly low. An active duty greater than F gives a raw output that is constantly high while running.
- R4: `invert` = 1 inverts the output in the same cycle, without changing the counter or the strobes.
- R5: A duty written with `dutyWr` goes to the holding register only. It reaches the output only after the next turning point has been registered (top or bottom), and it stays in effect until the turning point after that. A write in the middle of a ramp does not change the current half-frame.
- R6: While `runEn` is 0, the count is held at 0, both strobes are low, and `pwmOut` equals `invert`. The active duty follows the holding register. On release, the first running cycle has count 0.
- R7: `frameSize` is sampled only while `runEn` is 0. A change while running has no effect on the period. A sampled value of 0 is treated as 1.
- R8: Two instances that share their settings and are released on the same cycle give identical outputs. If one is released k cycles later, its outputs are those of the first delayed by k cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | 0 holds the counter at zero, 1 runs it |
| frameSize | input | CNT_W | Turning count F, sampled during hold |
| dutyIn | input | CNT_W+1 | Duty value for the holding register |
| dutyWr | input | 1 | Write strobe for the holding register |
| invert | input | 1 | Output polarity select |
| pwmOut | output | 1 | PWM output |
| peakStb | output | 1 | High for one cycle at the top turning point |
| valleyStb | output | 1 | High for one cycle at the bottom turning point |

## Verification
The bench builds the block with CNT_W = 4. A small counter like this makes it possible to sweep every frame size from 1 to 6 against every duty value from 0 to F+1 in both polarities. Expected waveforms come from the cycle index after release, taken modulo 2F. A second instance is released on the same cycle and also at delays of 3 and 5 cycles to check phase locking. Directed runs cover the following:
- reloads at the top and at the bottom turning points
- a frame-size change while running
- a zero frame size

// File: rtl/triPwmPkg.sv
package triPwmPkg;
  typedef struct packed {
    logic running;  // counter is advancing
    logic reload;   // copy holding duty into active duty this edge
  } pwmCtl_t;
endpackage

// File: rtl/triPwmCtrl.sv
module triPwmCtrl
  import triPwmPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [CNT_W-1:0] frameSize,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] frameQ,
  output pwmCtl_t          ctl,
  output logic             peakStb,
  output logic             valleyStb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic upQ;
  logic runQ;
  logic atTop;
  logic atBot;

  assign atTop = (cnt == frameQ);
  assign atBot = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      upQ    <= 1'b1;
      runQ   <= 1'b0;
      frameQ <= ONE;
    end else if (!runEn) begin
      cnt    <= '0;
      upQ    <= 1'b1;
      runQ   <= 1'b0;
      frameQ <= (frameSize == '0) ? ONE : frameSize;
    end else if (!runQ) begin
      runQ <= 1'b1;
    end else if (atTop) begin
      cnt <= cnt - ONE;
      upQ <= 1'b0;
    end else if (atBot) begin
      cnt <= cnt + ONE;
      upQ <= 1'b1;
    end else begin
      cnt <= upQ ? cnt + ONE : cnt - ONE;
    end
  end

  assign peakStb     = runQ && atTop;
  assign valleyStb   = runQ && atBot;
  assign ctl.running = runQ;
  assign ctl.reload  = !runEn || peakStb || valleyStb;
endmodule

// File: rtl/triPwmData.sv
module triPwmData
  import triPwmPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmCtl_t          ctl,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W:0]   dutyIn,
  input  logic             dutyWr,
  input  logic             invert,
  output logic [CNT_W:0]   actDuty,
  output logic             pwmOut
);
  logic [CNT_W:0] holdQ;
  logic           rawHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ   <= '0;
      actDuty <= '0;
    end else begin
      if (dutyWr)     holdQ   <= dutyIn;
      if (ctl.reload) actDuty <= holdQ;
    end
  end

  assign rawHigh = ctl.running && ({1'b0, cnt} < actDuty);
  assign pwmOut  = rawHigh ^ invert;
endmodule

// File: rtl/triPwmGen.sv
module triPwmGen
  import triPwmPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [CNT_W-1:0] frameSize,
  input  logic [CNT_W:0]   dutyIn,
  input  logic             dutyWr,
  input  logic             invert,
  output logic             pwmOut,
  output logic             peakStb,
  output logic             valleyStb
);
  pwmCtl_t          ctl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] frameQ;
  logic [CNT_W:0]   actDuty;

  triPwmCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .frameSize(frameSize),
    .cnt(cnt), .frameQ(frameQ), .ctl(ctl),
    .peakStb(peakStb), .valleyStb(valleyStb)
  );

  triPwmData #(.CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cnt(cnt),
    .dutyIn(dutyIn), .dutyWr(dutyWr), .invert(invert),
    .actDuty(actDuty), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/triPwmGen_chk.sv
module triPwmGen_chk
  import triPwmPkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             invert,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] frameQ,
  input logic [CNT_W:0]   actDuty,
  input pwmCtl_t          ctl,
  input logic             pwmOut,
  input logic             peakStb,
  input logic             valleyStb
);
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= frameQ); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.running && runEn) |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)); // R1

  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (actDuty == '0) |-> (pwmOut == invert)); // R3

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && ctl.running && !peakStb && !valleyStb) |=> $stable(actDuty)); // R5

  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (cnt == '0) && !ctl.running); // R6

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.running |-> (pwmOut == invert) && !peakStb && !valleyStb); // R6

  AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> $stable(frameQ)); // R7
endmodule

bind triPwmGen triPwmGen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .invert(invert), .cnt(cnt),
  .frameQ(frameQ), .actDuty(actDuty), .ctl(ctl), .pwmOut(pwmOut),
  .peakStb(peakStb), .valleyStb(valleyStb)
);

// File: tb/triPwmGen_tb.sv
module triPwmGen_tb;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic runB = 1'b0;
  logic [CNT_W-1:0] frameSize = '0;
  logic [CNT_W:0] dutyIn = '0;
  logic dutyWr = 1'b0;
  logic invert = 1'b0;
  logic pwmOut, peakStb, valleyStb;
  logic pwmB, peakB, valleyB;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  triPwmGen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .frameSize(frameSize),
    .dutyIn(dutyIn), .dutyWr(dutyWr), .invert(invert),
    .pwmOut(pwmOut), .peakStb(peakStb), .valleyStb(valleyStb)
  );

  triPwmGen #(.CNT_W(CNT_W)) u_dutB (
    .clk(clk), .rstN(rstN), .runEn(runB), .frameSize(frameSize),
    .dutyIn(dutyIn), .dutyWr(dutyWr), .invert(invert),
    .pwmOut(pwmB), .peakStb(peakB), .valleyStb(valleyB)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int triCnt(input int t, input int f);
    int p;
    p = t % (2 * f);
    return (p <= f) ? p : 2 * f - p;
  endfunction

  // Hold, load duty, release; then compare against arithmetic expectation.
  task automatic runCase(input int fIn, input int fExp, input int d, input bit inv,
                         input int lagB, input bit chgFrame);
    @(negedge clk);
    runEn = 1'b0; runB = 1'b0; frameSize = CNT_W'(fIn);
    dutyIn = (CNT_W+1)'(d); dutyWr = 1'b1; invert = inv;
    @(negedge clk);
    dutyWr = 1'b0;
    @(negedge clk);
    chk(pwmOut == inv && !peakStb && !valleyStb, "R6",
        {pwmOut, peakStb, valleyStb}, {inv, 2'b00});
    runEn = 1'b1;
    if (lagB == 0) runB = 1'b1;
    for (int t = 0; t < 4 * fExp + 4; t++) begin
      int c, p;
      bit ePwm;
      string tagP, tagS;
      @(negedge clk);
      c = triCnt(t, fExp);
      p = t % (2 * fExp);
      ePwm = (c < d) ^ inv;
      tagP = (d == 0 || d > fExp) ? "R3" : (inv ? "R4" : "R2");
      tagS = (chgFrame || fIn == 0) ? "R7" : "R1";
      chk(pwmOut == ePwm, tagP, pwmOut, ePwm);
      chk(peakStb == (p == fExp) && valleyStb == (p == 0), tagS,
          {peakStb, valleyStb}, {p == fExp, p == 0});
      if (t >= lagB) begin
        int cb, pb;
        bit eB;
        cb = triCnt(t - lagB, fExp);
        pb = (t - lagB) % (2 * fExp);
        eB = (cb < d) ^ inv;
        chk(pwmB == eB && peakB == (pb == fExp) && valleyB == (pb == 0), "R8",
            {pwmB, peakB, valleyB}, {eB, pb == fExp, pb == 0});
      end else begin
        chk(pwmB == inv && !peakB && !valleyB, "R8",
            {pwmB, peakB, valleyB}, {inv, 2'b00});
      end
      if (chgFrame && t == 2) frameSize = CNT_W'(fIn + 4);
      if (lagB > 0 && t == lagB - 1) runB = 1'b1;
    end
  endtask

  // Reload at the top and at the bottom: F=8, duty 3 -> 6 (top) -> 1 (bottom).
  task automatic runReload();
    @(negedge clk);
    runEn = 1'b0; runB = 1'b0; frameSize = CNT_W'(8);
    dutyIn = (CNT_W+1)'(3); dutyWr = 1'b1; invert = 1'b0;
    @(negedge clk);
    dutyWr = 1'b0;
    @(negedge clk);
    runEn = 1'b1;
    for (int t = 0; t <= 20; t++) begin
      int c, dNow;
      bit e;
      @(negedge clk);
      c = triCnt(t, 8);
      dNow = (t <= 8) ? 3 : ((t <= 16) ? 6 : 1);
      e = (c < dNow);
      chk(pwmOut == e, "R5", pwmOut, e);
      dutyWr = 1'b0;
      if (t == 3)  begin dutyIn = (CNT_W+1)'(6); dutyWr = 1'b1; end
      if (t == 12) begin dutyIn = (CNT_W+1)'(1); dutyWr = 1'b1; end
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #1_500_000;
    nChk++;
    nFail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(pwmOut == 1'b0 && !peakStb && !valleyStb, "R6",
        {pwmOut, peakStb, valleyStb}, 0);
    // R1 R2 R3 R4 R8: full sweep of frame, duty and polarity
    for (int f = 1; f <= 6; f++)
      for (int d = 0; d <= f + 1; d++)
        for (int inv = 0; inv <= 1; inv++)
          runCase(f, f, d, inv[0], 0, 1'b0);
    // R8: phase offsets
    runCase(5, 5, 3, 1'b0, 3, 1'b0);
    runCase(4, 4, 2, 1'b1, 5, 1'b0);
    // R7: frame change while running, and zero frame
    runCase(5, 5, 2, 1'b0, 0, 1'b1);
    runCase(0, 1, 1, 1'b0, 0, 1'b0);
    // R5: reloads at both turning points
    runReload();
    finishRun();
  end
endmodule